// File: doc/BRIEF.md
# Sequential Auto-Indexed Register Port

This block is a small register file reached through a single access port that has no address pins. An internal index counter chooses the target register. The counter starts at register 0 after reset, and every access moves it on to the next register, whether the access reads or writes. A host that wants to load or dump the whole file therefore issues a run of accesses to the same port, and the registers are visited in ascending order. After the last register the index wraps back to the first.

Each access is one clock cycle with chip select high. A read/not-write line chooses the direction. Write data is taken on the clock edge that ends the cycle. Read data is combinational during the cycle and shows the register at the current index, before the advance that the same access causes. A synchronous clear input moves the index back to register 0 and leaves the stored contents as they are, so software can restart a walk without losing state.

Top module: `seq_reg_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register and the index are set to zero, so the first access after reset targets register 0.
- R2: A cycle with `cs`=1, `rd_wn`=0 and `clr`=0 stores `wdata` into the register at the current index at that cycle's clock edge.
- R3: Every cycle with `cs`=1 and `clr`=0 advances the index by exactly one, for reads and writes alike. With the default 8 registers, the order is 0,1,...,7 and then 0 again.
- R4: A cycle with `cs`=0 and `clr`=0 leaves the index and all register contents unchanged.
- R5: A cycle with `clr`=1 sets the index to 0 and changes no register. `clr` takes priority over `cs`: an access in the same cycle is dropped, so it performs no write and no advance, and it returns zero read data.
- R6: While `cs`=1, `rd_wn`=1 and `clr`=0, `rdata` shows the register at the current index, before that access's advance. A read changes no register.
- R7: `rdata` is zero in any cycle that is not a read access (`cs`=0, `rd_wn`=0, or `clr`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous index restart to register 0 |
| cs | input | 1 | Chip select; high for one access per cycle |
| rd_wn | input | 1 | 1 = read access, 0 = write access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |

## Verification
The index is never visible directly, so a wrong index shows up only as data from the wrong register. A skipped or doubled advance, a missed wrap, or a clear that fails makes the very next read return another register's value, and the bench compares it with a model of the index computed arithmetically. A write that lands at the wrong index, or that happens on a cleared or idle cycle, is found when the walk next reaches the damaged register, which takes at most eight accesses. Each register holds a distinct pattern, so any misdirected access changes a later read.

// File: rtl/seqport_pkg.sv
// Package: shared sizing defaults and the decoded access type for the
// auto-indexed register port. Assumes nothing beyond IEEE 1800-2017.
package seqport_pkg;
    localparam int DEF_NUM_REGS = 8;
    localparam int DEF_DATA_W   = 8;

    // Decoded per-cycle access request after clear priority is applied.
    typedef struct packed {
        logic valid;    // an access takes effect this cycle
        logic is_read;  // 1 = read, 0 = write
    } access_t;
endpackage

// File: rtl/seq_index_counter.sv
// Module: seq_index_counter
// Holds the index of the register the next access will target. It advances
// by one, wrapping at NUM_REGS-1, on every cycle in which step is high, and it
// returns to zero on clr or reset. Assumes NUM_REGS >= 2.
module seq_index_counter #(
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_inc;

    // Next index after an advance, wrapping from the last register to zero.
    always_comb begin
        if (idx_q == LAST_IDX) idx_inc = '0;
        else                   idx_inc = idx_q + 1'b1;
    end

    // Index register: reset and clear to zero, otherwise advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= '0;
        else if (clr)   idx_q <= '0;
        else if (step)  idx_q <= idx_inc;
    end

    assign idx_o = idx_q;

    // R1: reset drives the index to zero.
    p_reset_idx_r1: assert property (@(posedge clk)
        !rst_n |=> (idx_o == '0));

    // R3: a step moves the index forward by one with wrap.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (idx_o == (($past(idx_o) == LAST_IDX) ? '0 : $past(idx_o) + 1'b1)));

    // R4: without step or clear the index holds.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(idx_o));

    // R5: clear returns the index to zero.
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (idx_o == '0));
endmodule

// File: rtl/seq_reg_bank.sv
// Module: seq_reg_bank
// Storage for NUM_REGS registers of DATA_W bits, presented flat. A single
// write port loads the register chosen by wr_idx. Assumes wr_idx < NUM_REGS.
module seq_reg_bank #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            logic              hit;
            logic [DATA_W-1:0] q;

            // Select decode for this register slot.
            assign hit = wr_en && (wr_idx == IDX_W'(gi));

            // Register slot: clear on reset, load on a write hit.
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= '0;
                else if (hit) q <= wr_data;
            end

            assign regs_o[gi*DATA_W +: DATA_W] = q;

            // R1: reset clears every slot.
            p_reset_reg_r1: assert property (@(posedge clk)
                !rst_n |=> (regs_o[gi*DATA_W +: DATA_W] == '0));

            // R2: a write aimed at this slot stores the write data.
            p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == IDX_W'(gi)) |=> (regs_o[gi*DATA_W +: DATA_W] == $past(wr_data)));

            // R5/R6: a slot not written keeps its value.
            p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_idx == IDX_W'(gi)) |=> $stable(regs_o[gi*DATA_W +: DATA_W]));
        end
    endgenerate
endmodule

// File: rtl/seq_read_mux.sv
// Module: seq_read_mux
// Returns the register chosen by rd_idx while rd_en is high, and zero
// otherwise. Purely combinational; assumes rd_idx < NUM_REGS.
module seq_read_mux #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                       rd_en,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic [NUM_REGS*DATA_W-1:0] regs_i,
    output logic [DATA_W-1:0]          rdata_o
);
    // AND-OR select across all slots, gated by the read enable.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_en && (rd_idx == IDX_W'(i))) rdata_o = regs_i[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/seq_reg_port.sv
// Module: seq_reg_port
// Top level of the auto-indexed register port. It decodes each cycle into an
// access, with clear taking priority, and connects the index counter, the
// register bank and the read mux. Assumes one access per cycle while cs is high.
module seq_reg_port
    import seqport_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int DATA_W   = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cs,
    input  logic              rd_wn,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = $clog2(NUM_REGS);

    access_t                    acc;
    logic [IDX_W-1:0]           idx;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;

    // Access decode: clear cancels any access requested in the same cycle.
    always_comb begin
        acc.valid   = cs && !clr;
        acc.is_read = rd_wn;
    end

    seq_index_counter #(.NUM_REGS(NUM_REGS)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (acc.valid),
        .idx_o (idx)
    );

    seq_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc.valid && !acc.is_read),
        .wr_idx  (idx),
        .wr_data (wdata),
        .regs_o  (regs_flat)
    );

    seq_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rmux (
        .rd_en   (acc.valid && acc.is_read),
        .rd_idx  (idx),
        .regs_i  (regs_flat),
        .rdata_o (rdata)
    );

    // R7: port-level check that non-read cycles return zero.
    p_quiet_rdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd_wn && !clr) |-> (rdata == '0));

    // R6: a read cycle returns what the bank holds at the current index.
    p_read_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd_wn && !clr) |-> (rdata == regs_flat[idx*DATA_W +: DATA_W]));
endmodule

// File: tb/sim_seq_reg_port.sv
// Bench for seq_reg_port: walks the index through full and partial sweeps,
// mixing reads, writes, idles and clears, against an arithmetic model.
module sim_seq_reg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       cs = 1'b0;
    logic       rd_wn = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;
    int m_idx  = 0;
    logic [7:0] m_reg [8];

    always #2 clk = ~clk;   // 250 MHz

    seq_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cs(cs),
        .rd_wn(rd_wn), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rdata=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check rdata mid-cycle, update model after the edge.
    task automatic cycle(logic c, logic rd, logic cl, logic [7:0] d, string req, bit chk);
        @(negedge clk);
        cs = c; rd_wn = rd; clr = cl; wdata = d;
        #1;
        if (chk) check(req, rdata, (c && rd && !cl) ? m_reg[m_idx] : 8'h00);
        @(posedge clk);
        if (cl) m_idx = 0;
        else if (c) begin
            if (!rd) m_reg[m_idx] = d;
            m_idx = (m_idx + 1) % 8;
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R7: idle output after reset is zero
        #1 check("R7 idle after reset", rdata, 8'h00);
        // R1: every register reads zero; R3 wrap across nine reads
        for (int i = 0; i < 9; i++) cycle(1, 1, 0, 8'h00, "R1 reset contents", 1);
        // R2/R3: fill all eight through a wrap-aligned walk
        for (int i = 0; i < 8; i++) cycle(1, 0, 0, 8'(i * 37 + 5), "R7 write cycle", 1);
        for (int i = 0; i < 10; i++) cycle(1, 1, 0, 8'h00, "R2 R3 readback", 1);
        // R4: idle cycles do not move the index
        for (int i = 0; i < 5; i++) cycle(0, 1, 0, 8'hFF, "R7 idle", 1);
        cycle(1, 1, 0, 8'h00, "R4 idle hold", 1);
        // R5: clear restarts at register 0 with contents kept
        cycle(0, 0, 1, 8'h00, "R5 clear", 1);
        cycle(1, 1, 0, 8'h00, "R5 after clear", 1);
        cycle(1, 1, 0, 8'h00, "R5 after clear", 1);
        // R5: clear with a simultaneous write drops the write
        cycle(1, 0, 1, 8'hA5, "R5 clr priority", 1);
        cycle(1, 1, 1, 8'h00, "R5 clr read zero", 1);
        for (int i = 0; i < 8; i++) cycle(1, 1, 0, 8'h00, "R5 no write on clr", 1);
        // R6: reads leave contents intact over two more laps
        for (int i = 0; i < 16; i++) cycle(1, 1, 0, 8'h00, "R6 read stable", 1);
        // Mixed sweep: pattern chosen arithmetically from the step number
        for (int i = 0; i < 300; i++) begin
            int k = (i * 7 + 3) % 11;
            cycle(k != 0, k < 6, k == 10, 8'(i * 13 + 1), "R3 mixed sweep", 1);
        end
        // R1: reset in mid-walk clears contents and index
        @(negedge clk); rst_n = 1'b0; cs = 0; clr = 0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1;
        m_idx = 0;
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        for (int i = 0; i < 8; i++) cycle(1, 1, 0, 8'h00, "R1 second reset", 1);
        @(negedge clk); cs = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule